// File: doc/BRIEF.md
# DMA Channel Request Arbiter

This block sits between eight DMA channel request lines and the processor core's bus-ownership handshake. It masks requests from disabled channels and picks one winner. Each channel has a per-channel snoop bit. When set, the winning channel raises a snoop-type bus request, which lets the transfer reach the memories behind the core's own data path. When clear, it raises a general-type request.

Snoop-class requests outrank general-class ones. Within a class, the lowest-numbered channel wins. After the grant arrives, the block gives a one-cycle acknowledge to the winner. It then holds the bus until the transfer logic reports that the last unit is done, or until the core asks for the bus back at the end of a unit. Channels 0 and 4 also accept an external request line and mirror their acknowledge onto an external acknowledge output.

The control is a six-state machine:
- IDLE: waits for an enabled request, then latches the winner and its class. IDLE to REQUEST when any enabled request is present.
- REQUEST: raises the bus request for one cycle. REQUEST to WAIT_GNT unconditionally.
- WAIT_GNT: holds the request until the grant. WAIT_GNT to ACK on grant.
- ACK: drives the one-cycle acknowledge. ACK to XFER unconditionally.
- XFER: holds the bus across transfer units. XFER to RELEASE when a unit completes and it is either the last unit or a release request is present.
- RELEASE: drops the request and waits for the grant to fall. RELEASE to IDLE when the grant is low.

Top module: `dma_req_arbiter`

## Requirements
- R1: While reset is asserted, and right after it, snoop_req, gen_req, ch_ack and ext_ack are all zero.
- R2: A channel whose ch_en bit is 0 is never served. If no enabled channel requests, snoop_req and gen_req both stay 0.
- R3: The winning channel's ch_snoop bit selects the class. Bit value 1 raises snoop_req only, and 0 raises gen_req only. The two are never high together.
- R4: If any enabled snoop channel requests, the lowest-numbered such channel wins. Otherwise the lowest-numbered enabled general channel wins.
- R5: The bus request stays high until bus_grant. ch_ack then goes high for exactly one cycle, one-hot on the winner, and only while bus_grant is high.
- R6: Once a winner is latched, later request changes do not alter the winner or the request class until the block has passed through RELEASE. The class never switches without a low cycle in between.
- R7: unit_done together with unit_last during XFER drops the bus request on the next cycle. The block stays in RELEASE until bus_grant falls.
- R8: unit_done together with rel_req during XFER releases the bus even when unit_last is 0. The interrupted channel, if still requesting, is arbitrated again afterwards and wins again.
- R9: ext_req[0] requests channel 0 and ext_req[1] requests channel 4, subject to ch_en. ext_ack[0] follows ch_ack[0] and ext_ack[1] follows ch_ack[4].
- R10: unit_done with unit_last 0 and rel_req 0 keeps the block transferring, with the bus request still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_req | input | 8 | Per-channel transfer request |
| ext_req | input | 2 | External requests for channels 0 and 4 |
| ch_en | input | 8 | Per-channel enable |
| ch_snoop | input | 8 | Per-channel snoop-path selection |
| bus_grant | input | 1 | Bus ownership granted by the core |
| rel_req | input | 1 | Core asks for the bus back |
| unit_done | input | 1 | Current transfer unit completed |
| unit_last | input | 1 | Completed unit is the final one |
| snoop_req | output | 1 | Snoop-type bus ownership request |
| gen_req | output | 1 | General-type bus ownership request |
| ch_ack | output | 8 | One-cycle acknowledge to the winning channel |
| ext_ack | output | 2 | External acknowledge for channels 0 and 4 |

## Verification
The main function is swept over all 256 request patterns. This is done under four combinations of enable and snoop masks: all enabled with no snoop, all enabled with all snoop, and two mixed masks. The mixed masks separate the snoop-first rule from plain lowest-number priority and show that disabled channels are masked. Directed sequences then raise a higher-priority request mid-transfer to show that arbitration is held. They also complete units that are not the last and issue a core release request, to separate the three ways out of XFER. Finally, they drive the external request lines with the channel enabled and disabled.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQUEST,
        ST_WAIT_GNT,
        ST_ACK,
        ST_XFER,
        ST_RELEASE
    } arb_state_t;
endpackage

// File: rtl/dma_prio_enc.sv
// Lowest-index-first priority encoder.
module dma_prio_enc #(
    parameter int N  = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec,
    output logic          hit,
    output logic [IW-1:0] idx
);
    always_comb begin
        hit = |vec;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/dma_req_mask.sv
// Merges internal and external request sources and applies the enables.
module dma_req_mask #(
    parameter int NUM_CH   = 8,
    parameter int EXT_CH_A = 0,
    parameter int EXT_CH_B = 4
) (
    input  logic [NUM_CH-1:0] ch_req,
    input  logic [1:0]        ext_req,
    input  logic [NUM_CH-1:0] ch_en,
    output logic [NUM_CH-1:0] live
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        if (g == EXT_CH_A) begin : g_ext_a
            assign live[g] = (ch_req[g] | ext_req[0]) & ch_en[g];
        end else if (g == EXT_CH_B) begin : g_ext_b
            assign live[g] = (ch_req[g] | ext_req[1]) & ch_en[g];
        end else begin : g_int
            assign live[g] = ch_req[g] & ch_en[g];
        end
    end
endmodule

// File: rtl/dma_class_pick.sv
// Snoop class first, then lowest channel number within the class.
module dma_class_pick #(
    parameter int NUM_CH = 8,
    localparam int IW    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [NUM_CH-1:0] live,
    input  logic [NUM_CH-1:0] snoop,
    output logic              any,
    output logic [IW-1:0]     win_idx,
    output logic              win_snoop
);
    logic          s_hit, a_hit;
    logic [IW-1:0] s_idx, a_idx;

    dma_prio_enc #(.N(NUM_CH)) u_snoop_enc (
        .vec (live & snoop),
        .hit (s_hit),
        .idx (s_idx)
    );

    dma_prio_enc #(.N(NUM_CH)) u_gen_enc (
        .vec (live & ~snoop),
        .hit (a_hit),
        .idx (a_idx)
    );

    assign any       = s_hit | a_hit;
    assign win_snoop = s_hit;
    assign win_idx   = s_hit ? s_idx : a_idx;
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
    import dma_arb_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int EXT_CH_A = 0,
    parameter int EXT_CH_B = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ch_req,
    input  logic [1:0]        ext_req,
    input  logic [NUM_CH-1:0] ch_en,
    input  logic [NUM_CH-1:0] ch_snoop,
    input  logic              bus_grant,
    input  logic              rel_req,
    input  logic              unit_done,
    input  logic              unit_last,
    output logic              snoop_req,
    output logic              gen_req,
    output logic [NUM_CH-1:0] ch_ack,
    output logic [1:0]        ext_ack
);
    localparam int IW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    arb_state_t    st, st_nxt;
    logic [NUM_CH-1:0] live;
    logic          any_live, pick_snoop;
    logic [IW-1:0] pick_idx;
    logic [IW-1:0] win_q;
    logic          cls_q;

    dma_req_mask #(
        .NUM_CH   (NUM_CH),
        .EXT_CH_A (EXT_CH_A),
        .EXT_CH_B (EXT_CH_B)
    ) u_mask (
        .ch_req  (ch_req),
        .ext_req (ext_req),
        .ch_en   (ch_en),
        .live    (live)
    );

    dma_class_pick #(.NUM_CH(NUM_CH)) u_pick (
        .live      (live),
        .snoop     (ch_snoop),
        .any       (any_live),
        .win_idx   (pick_idx),
        .win_snoop (pick_snoop)
    );

    // Next-state logic
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE:     if (any_live)  st_nxt = ST_REQUEST;
            ST_REQUEST:                 st_nxt = ST_WAIT_GNT;
            ST_WAIT_GNT: if (bus_grant) st_nxt = ST_ACK;
            ST_ACK:                     st_nxt = ST_XFER;
            ST_XFER:     if (unit_done && (unit_last || rel_req))
                                        st_nxt = ST_RELEASE;
            ST_RELEASE:  if (!bus_grant) st_nxt = ST_IDLE;
            default:                    st_nxt = ST_IDLE;
        endcase
    end

    // State register; winner latched only on leaving IDLE
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            win_q <= '0;
            cls_q <= 1'b0;
        end else begin
            st <= st_nxt;
            if (st == ST_IDLE && any_live) begin
                win_q <= pick_idx;
                cls_q <= pick_snoop;
            end
        end
    end

    // Outputs
    always_comb begin
        logic holding;
        holding   = (st == ST_REQUEST) || (st == ST_WAIT_GNT) ||
                    (st == ST_ACK)     || (st == ST_XFER);
        snoop_req = holding &&  cls_q;
        gen_req   = holding && !cls_q;
        ch_ack    = '0;
        if (st == ST_ACK) ch_ack[win_q] = 1'b1;
        ext_ack   = {ch_ack[EXT_CH_B], ch_ack[EXT_CH_A]};
    end
endmodule

// File: rtl/dma_req_arbiter_chk.sv
module dma_req_arbiter_chk
    import dma_arb_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input logic              clk,
    input logic              rst_n,
    input arb_state_t        st,
    input logic              bus_grant,
    input logic              rel_req,
    input logic              unit_done,
    input logic              unit_last,
    input logic              snoop_req,
    input logic              gen_req,
    input logic [NUM_CH-1:0] ch_ack
);
    p_one_class_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(snoop_req && gen_req));

    p_ack_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_ack));

    p_ack_needs_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_ack) |-> bus_grant);

    p_ack_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_ack) |=> (ch_ack == '0));

    p_snoop_no_swap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_req |=> !gen_req);

    p_gen_no_swap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        gen_req |=> !snoop_req);

    p_end_drops_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_XFER && unit_done && unit_last) |=> !(snoop_req || gen_req));

    p_release_waits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RELEASE && bus_grant) |=> (st == ST_RELEASE));

    p_core_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_XFER && unit_done && rel_req) |=> (st == ST_RELEASE));

    p_mid_unit_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_XFER && unit_done && !unit_last && !rel_req) |=> (snoop_req || gen_req));
endmodule

bind dma_req_arbiter dma_req_arbiter_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .st        (st),
    .bus_grant (bus_grant),
    .rel_req   (rel_req),
    .unit_done (unit_done),
    .unit_last (unit_last),
    .snoop_req (snoop_req),
    .gen_req   (gen_req),
    .ch_ack    (ch_ack)
);

// File: tb/dma_req_arbiter_tb.sv
module dma_req_arbiter_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] ch_req = '0, ch_en = '0, ch_snoop = '0;
    logic [1:0] ext_req = '0;
    logic       bus_grant = 0, rel_req = 0, unit_done = 0, unit_last = 0;
    logic       snoop_req, gen_req;
    logic [7:0] ch_ack;
    logic [1:0] ext_ack;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    dma_req_arbiter u_dut (
        .clk(clk), .rst_n(rst_n), .ch_req(ch_req), .ext_req(ext_req),
        .ch_en(ch_en), .ch_snoop(ch_snoop), .bus_grant(bus_grant),
        .rel_req(rel_req), .unit_done(unit_done), .unit_last(unit_last),
        .snoop_req(snoop_req), .gen_req(gen_req), .ch_ack(ch_ack),
        .ext_ack(ext_ack)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            summary();
        end
    end

    // Expected winner from the requirements: -1 when nothing is served
    function automatic int exp_win(logic [7:0] r, logic [7:0] en,
                                   logic [7:0] sn, output bit snp);
        logic [7:0] m;
        m = r & en;
        snp = 0;
        for (int i = 0; i < 8; i++) if (m[i] && sn[i]) begin snp = 1; return i; end
        for (int i = 0; i < 8; i++) if (m[i]) return i;
        return -1;
    endfunction

    // Runs from idle up to the first XFER cycle
    task automatic start_txn(int exp, bit exp_s);
        int n = 0;
        while (!(snoop_req || gen_req) && n < 8) begin @(negedge clk); n++; end
        chk("R3 request class", {30'd0, snoop_req, gen_req}, exp_s ? 2 : 1);
        chk("R5 no ack before grant", ch_ack, 0);
        @(negedge clk);
        chk("R5 request held without grant", snoop_req | gen_req, 1);
        bus_grant = 1;
        n = 0;
        while (ch_ack == 0 && n < 6) begin @(negedge clk); n++; end
        chk("R4 winner ack", ch_ack, 1 << exp);
        chk("R9 external ack", ext_ack, (exp == 0) ? 1 : (exp == 4) ? 2 : 0);
        @(negedge clk);
        chk("R5 ack lasts one cycle", ch_ack, 0);
    endtask

    task automatic finish_txn();
        unit_done = 1; unit_last = 1;
        @(negedge clk);
        unit_done = 0; unit_last = 0;
        chk("R7 request dropped after last unit", snoop_req | gen_req, 0);
        ch_req = '0; ext_req = '0;
        @(negedge clk);
        chk("R7 stays released while grant high", snoop_req | gen_req, 0);
        bus_grant = 0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        logic [7:0] en_set [4] = '{8'hFF, 8'hFF, 8'h5A, 8'hE7};
        logic [7:0] sn_set [4] = '{8'h00, 8'hFF, 8'h3C, 8'h91};
        bit s;
        int w;

        repeat (3) @(negedge clk);
        chk("R1 reset requests", {30'd0, snoop_req, gen_req}, 0);
        chk("R1 reset ack", {22'd0, ch_ack, ext_ack}, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 after reset", {20'd0, snoop_req, gen_req, ch_ack, ext_ack}, 0);

        // Sweep all request patterns under four mask configurations
        for (int c = 0; c < 4; c++) begin
            for (int r = 0; r < 256; r++) begin
                ch_en = en_set[c]; ch_snoop = sn_set[c]; ch_req = 8'(r);
                w = exp_win(8'(r), en_set[c], sn_set[c], s);
                if (w < 0) begin
                    repeat (3) @(negedge clk);
                    chk("R2 no enabled request gives no bus request",
                        snoop_req | gen_req, 0);
                    ch_req = '0;
                end else begin
                    start_txn(w, s);
                    finish_txn();
                end
            end
        end

        // R6 hold, R10 mid-unit, R8 core release and re-arbitration
        ch_en = 8'hFF; ch_snoop = 8'h01; ch_req = 8'h20;
        start_txn(5, 0);
        unit_done = 1;
        @(negedge clk);
        unit_done = 0;
        chk("R10 non-last unit keeps gen_req", gen_req, 1);
        ch_req = 8'h21;
        repeat (3) @(negedge clk);
        chk("R6 class held against new snoop request", {30'd0, snoop_req, gen_req}, 1);
        chk("R6 no second ack", ch_ack, 0);
        ch_req = 8'h20;
        rel_req = 1; unit_done = 1;
        @(negedge clk);
        rel_req = 0; unit_done = 0;
        chk("R8 core release drops request", snoop_req | gen_req, 0);
        bus_grant = 0;
        @(negedge clk);
        start_txn(5, 0);
        finish_txn();

        // R9 external request lines
        ch_snoop = 8'h00; ch_en = 8'hFF; ext_req = 2'b10;
        start_txn(4, 0);
        finish_txn();
        ch_snoop = 8'h01; ext_req = 2'b01;
        start_txn(0, 1);
        finish_txn();
        ch_en = 8'hFE; ext_req = 2'b01;
        repeat (4) @(negedge clk);
        chk("R9 disabled external channel not served", snoop_req | gen_req, 0);
        ext_req = 2'b00;

        summary();
    end
endmodule